// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block keeps the 24-bit program counter of a wide-word processor and chooses the counter's next value once per instruction. It decodes a small set of control fields in the 64-bit instruction word. A 2-bit source selector picks one of four candidates: an address carried in the instruction, the address the ALU computed (dispatch), the return address offered by the call stack, or the incremented counter. For the source that uses the instruction's own address, the instruction class shapes the target further. A short branch keeps the page bits of PC+1 and replaces the low 12 bits. A call into low memory builds a 16-word-aligned address below 4096. A long jump or call takes all 24 bits.

Each completed instruction evaluates a 3-bit condition code against the ALU flags and a control bit. The result is stored so that the next conditional branch or jump can use it. An instruction whose trap bit is set does not change the counter or the stored condition. Instead it raises a one-cycle trap request to the trap logic outside the block. A two-state controller tracks this. In state SQ_RUN, strobes commit normally. A strobe carrying the trap bit moves the controller to SQ_TRAP. That state drives the trap request, ignores any strobe, and always returns to SQ_RUN on the next clock. Fetch, the call stack, the ALU and the trap handler are outside the block.

Top module: `npc_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the counter to 0, clears the stored condition and clears the trap request. A conditional branch issued first after reset therefore falls through to PC+1.
- R2: While advance is low, the counter and the stored condition keep their values.
- R3: Source selector instr[57:56]=11 loads PC+1, wrapping from 0xFFFFFF to 0.
- R4: With selector 00 and format instr[60:58]=010, the counter loads instr[23:0]. When instr[61]=0 and call op instr[50:48] has bit 49 clear, the load happens only if the stored condition is 1; otherwise the counter loads PC+1.
- R5: With selector 00, format bits instr[59:58]=00 and instr[49]=0, the target is PC+1 bits 23:12 joined with instr[11:0]. It is conditional on the stored condition when instr[61]=0.
- R6: With selector 00, format bits instr[59:58]=00 and instr[49]=1, the target is zero except that bits 11:4 come from instr[11:4].
- R7: Selector 01 loads the ALU address. Bits 3:0 are forced to zero when the alignment flag is set. That flag is instr[3] when format bits instr[59:58]=00 and instr[49]=1, and instr[61] otherwise.
- R8: Selector 10 with call op 100 loads the return address from the call stack.
- R9: Every strobe that is not trapped stores the condition given by instr[36:34]: 000 true, 001 jindir, 010 Z, 011 not Z, 100 V xor N, 101 not (V xor N), 110 not ((V xor N) or Z), 111 (V xor N) or Z.
- R10: A strobe with instr[62]=1 in SQ_RUN leaves the counter and the stored condition unchanged and raises trap_req for exactly the next cycle (SQ_TRAP). A strobe during that cycle is ignored.
- R11: Selector 10 with a call op other than 100 asserts illegal. So does a branch or jump (selector 00, format 010 or format bits 00, instr[49]=0) carrying call op 100. A strobe of such an instruction loads PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | One-cycle strobe ending the current instruction |
| instr | input | 64 | Current instruction word |
| alu_addr | input | 24 | ALU output used as dispatch target |
| ret_addr | input | 24 | Return address from the call stack |
| flag_z | input | 1 | ALU zero flag |
| flag_n | input | 1 | ALU negative flag |
| flag_v | input | 1 | ALU overflow flag |
| jindir | input | 1 | Control bit tested by condition code 001 |
| pc | output | 24 | Current program counter |
| cond_flag | output | 1 | Stored condition from the previous instruction |
| trap_req | output | 1 | Pre-execution trap request |
| illegal | output | 1 | Illegal selector/call-op combination in instr |

## Verification
The assertions assume that instr, advance and the flags are steady around the clock edge, and that advance is a level sampled at each edge rather than a counted pulse. The checks on the counter also rely on the call stack and ALU inputs holding their values over the edge that commits an instruction. The bench changes every input only on the falling edge and lowers advance after one cycle. The only exception is the trap scenario, which deliberately holds advance high into SQ_TRAP. The bench reads results on the following falling edge.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int TRAP_BIT  = 62;
    localparam int AUX_BIT   = 61;
    localparam int FMT_HI    = 60;
    localparam int FMT_LO    = 58;
    localparam int SRC_HI    = 57;
    localparam int SRC_LO    = 56;
    localparam int CH_HI     = 50;
    localparam int CH_LO     = 48;
    localparam int JC_HI     = 36;
    localparam int JC_LO     = 34;
    localparam int CDISP_X16 = 3;

    localparam logic [2:0] CH_RETURN = 3'b100;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'b00,
        SRC_DISP = 2'b01,
        SRC_RET  = 2'b10,
        SRC_INC  = 2'b11
    } npc_src_e;

    typedef enum logic [2:0] {
        JC_ALWAYS  = 3'd0,
        JC_JINDIR  = 3'd1,
        JC_ZERO    = 3'd2,
        JC_NONZERO = 3'd3,
        JC_LT      = 3'd4,
        JC_GE      = 3'd5,
        JC_GT      = 3'd6,
        JC_LE      = 3'd7
    } jcond_e;

    typedef enum logic [2:0] {
        TK_INC      = 3'd0,
        TK_FULL     = 3'd1,
        TK_PAGE     = 3'd2,
        TK_LOWCALL  = 3'd3,
        TK_DISPATCH = 3'd4,
        TK_RETURN   = 3'd5
    } tgt_kind_e;

    typedef enum logic {
        SQ_RUN  = 1'b0,
        SQ_TRAP = 1'b1
    } seq_state_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int IR_W = 64
) (
    input  logic [IR_W-1:0] instr,
    input  logic            cond_q,
    output tgt_kind_e       kind,
    output logic            x16,
    output logic            illegal
);

    logic [2:0] fmt;
    logic [2:0] chop;
    npc_src_e   src;
    logic       short_fmt;
    logic       long_fmt;
    logic       callish;
    logic       is_ret;
    logic       take_ok;

    assign fmt       = instr[FMT_HI:FMT_LO];
    assign chop      = instr[CH_HI:CH_LO];
    assign src       = npc_src_e'(instr[SRC_HI:SRC_LO]);
    assign short_fmt = (fmt[1:0] == 2'b00);
    assign long_fmt  = (fmt == 3'b010);
    assign callish   = chop[1];
    assign is_ret    = (chop == CH_RETURN);
    assign take_ok   = instr[AUX_BIT] | cond_q;

    always_comb begin
        kind    = TK_INC;
        x16     = 1'b0;
        illegal = 1'b0;
        unique case (src)
            SRC_IMM: begin
                if (short_fmt && !callish) begin
                    if (is_ret)       illegal = 1'b1;
                    else if (take_ok) kind = TK_PAGE;
                end else if (short_fmt) begin
                    kind = TK_LOWCALL;
                end else if (long_fmt && !callish) begin
                    if (is_ret)       illegal = 1'b1;
                    else if (take_ok) kind = TK_FULL;
                end else begin
                    kind = TK_FULL;
                end
            end
            SRC_DISP: begin
                kind = TK_DISPATCH;
                x16  = (short_fmt && callish) ? instr[CDISP_X16] : instr[AUX_BIT];
            end
            SRC_RET: begin
                if (is_ret) kind = TK_RETURN;
                else        illegal = 1'b1;
            end
            SRC_INC: kind = TK_INC;
        endcase
    end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [2:0] code,
    input  logic       flag_z,
    input  logic       flag_n,
    input  logic       flag_v,
    input  logic       jindir,
    output logic       pass
);

    logic lt;
    assign lt = flag_v ^ flag_n;

    always_comb begin
        unique case (jcond_e'(code))
            JC_ALWAYS:  pass = 1'b1;
            JC_JINDIR:  pass = jindir;
            JC_ZERO:    pass = flag_z;
            JC_NONZERO: pass = ~flag_z;
            JC_LT:      pass = lt;
            JC_GE:      pass = ~lt;
            JC_GT:      pass = ~(lt | flag_z);
            JC_LE:      pass = lt | flag_z;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int PC_W    = 24,
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 4
) (
    input  logic [PC_W-1:0] pc,
    input  tgt_kind_e       kind,
    input  logic            x16,
    input  logic [PC_W-1:0] imm,
    input  logic [PC_W-1:0] alu_addr,
    input  logic [PC_W-1:0] ret_addr,
    output logic [PC_W-1:0] next_pc
);

    localparam logic [PC_W-1:0] LOW_ONES   = PC_W'((1 << ALIGN_W) - 1);
    localparam logic [PC_W-1:0] ALIGN_MASK = ~LOW_ONES;

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] low_call;

    assign pc_inc = pc + PC_W'(1);

    always_comb begin
        low_call = '0;
        low_call[PAGE_W-1:ALIGN_W] = imm[PAGE_W-1:ALIGN_W];
    end

    always_comb begin
        case (kind)
            TK_PAGE:     next_pc = {pc_inc[PC_W-1:PAGE_W], imm[PAGE_W-1:0]};
            TK_LOWCALL:  next_pc = low_call;
            TK_FULL:     next_pc = imm;
            TK_DISPATCH: next_pc = x16 ? (alu_addr & ALIGN_MASK) : alu_addr;
            TK_RETURN:   next_pc = ret_addr;
            default:     next_pc = pc_inc;
        endcase
    end

endmodule

// File: rtl/npc_ctrl_fsm.sv
module npc_ctrl_fsm
    import npc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic trap_bit,
    output logic trap_req,
    output logic commit
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        trap_req = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            SQ_RUN: begin
                if (advance && trap_bit) state_d = SQ_TRAP;
                commit = advance && !trap_bit;
            end
            SQ_TRAP: begin
                trap_req = 1'b1;
                state_d  = SQ_RUN;
            end
        endcase
    end

endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
    import npc_pkg::*;
#(
    parameter int PC_W    = 24,
    parameter int IR_W    = 64,
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic [IR_W-1:0] instr,
    input  logic [PC_W-1:0] alu_addr,
    input  logic [PC_W-1:0] ret_addr,
    input  logic            flag_z,
    input  logic            flag_n,
    input  logic            flag_v,
    input  logic            jindir,
    output logic [PC_W-1:0] pc,
    output logic            cond_flag,
    output logic            trap_req,
    output logic            illegal
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] next_pc;
    logic            cond_q;
    logic            cond_now;
    logic            commit;
    logic            x16;
    tgt_kind_e       kind;

    npc_decode #(.IR_W(IR_W)) u_dec (
        .instr   (instr),
        .cond_q  (cond_q),
        .kind    (kind),
        .x16     (x16),
        .illegal (illegal)
    );

    npc_cond_eval u_cond (
        .code   (instr[JC_HI:JC_LO]),
        .flag_z (flag_z),
        .flag_n (flag_n),
        .flag_v (flag_v),
        .jindir (jindir),
        .pass   (cond_now)
    );

    npc_target #(.PC_W(PC_W), .PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)) u_tgt (
        .pc       (pc_q),
        .kind     (kind),
        .x16      (x16),
        .imm      (instr[PC_W-1:0]),
        .alu_addr (alu_addr),
        .ret_addr (ret_addr),
        .next_pc  (next_pc)
    );

    npc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .trap_bit (instr[TRAP_BIT]),
        .trap_req (trap_req),
        .commit   (commit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            cond_q <= 1'b0;
        end else if (commit) begin
            pc_q   <= next_pc;
            cond_q <= cond_now;
        end
    end

    assign pc        = pc_q;
    assign cond_flag = cond_q;

endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk #(
    parameter int PC_W = 24,
    parameter int IR_W = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            advance,
    input logic [IR_W-1:0] instr,
    input logic [PC_W-1:0] ret_addr,
    input logic [PC_W-1:0] pc,
    input logic            cond_flag,
    input logic            trap_req,
    input logic            illegal
);

    logic live;
    assign live = advance && !trap_req && !instr[62];

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(pc) && $stable(cond_flag)));

    assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (live && instr[57:56] == 2'b11) |=> pc == $past(pc) + PC_W'(1));

    assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (live && instr[60:56] == 5'b01000 && instr[61] && instr[50:48] != 3'b100)
        |=> pc == $past(instr[PC_W-1:0]));

    assert_return_R8: assert property (@(posedge clk) disable iff (rst)
        (live && instr[57:56] == 2'b10 && instr[50:48] == 3'b100)
        |=> pc == $past(ret_addr));

    assert_trap_R10: assert property (@(posedge clk) disable iff (rst)
        (advance && instr[62] && !trap_req)
        |=> (trap_req && $stable(pc) && $stable(cond_flag)));

    assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (!trap_req && $stable(pc) && $stable(cond_flag)));

    assert_illegal_R11: assert property (@(posedge clk) disable iff (rst)
        (instr[57:56] == 2'b10 && instr[50:48] != 3'b100) |-> illegal);

endmodule

bind npc_sequencer npc_sequencer_chk #(.PC_W(PC_W), .IR_W(IR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .instr     (instr),
    .ret_addr  (ret_addr),
    .pc        (pc),
    .cond_flag (cond_flag),
    .trap_req  (trap_req),
    .illegal   (illegal)
);

// File: tb/npc_sequencer_test.sv
`timescale 1ns/1ps
module npc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        advance;
    logic [63:0] instr;
    logic [23:0] alu_addr;
    logic [23:0] ret_addr;
    logic        flag_z, flag_n, flag_v, jindir;
    logic [23:0] pc;
    logic        cond_flag, trap_req, illegal;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    npc_sequencer uut (
        .clk(clk), .rst(rst), .advance(advance), .instr(instr),
        .alu_addr(alu_addr), .ret_addr(ret_addr),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .jindir(jindir),
        .pc(pc), .cond_flag(cond_flag), .trap_req(trap_req), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic trap, input logic b61,
                                       input logic [2:0] fmt, input logic [1:0] src,
                                       input logic [2:0] ch, input logic [2:0] jc,
                                       input logic [23:0] low);
        logic [63:0] w;
        w = '0;
        w[62] = trap; w[61] = b61; w[60:58] = fmt; w[57:56] = src;
        w[50:48] = ch; w[36:34] = jc; w[23:0] = low;
        return w;
    endfunction

    function automatic logic cond_exp(input int code, input logic z, input logic n,
                                      input logic v, input logic j);
        logic lt;
        lt = v ^ n;
        case (code)
            0: return 1'b1;
            1: return j;
            2: return z;
            3: return !z;
            4: return lt;
            5: return !lt;
            6: return !(lt || z);
            default: return lt || z;
        endcase
    endfunction

    task automatic step(input logic [63:0] w);
        @(negedge clk);
        instr = w; advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        instr = mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b000, 24'h0);
    endtask

    // unconditional jump with always-true condition: loads target, stores 1
    task automatic goto(input logic [23:0] a);
        step(mk(0, 1, 3'b010, 2'b00, 3'b000, 3'b000, a));
    endtask

    task automatic t_reset;
        rst = 1'b1; advance = 1'b0; instr = '0;
        alu_addr = '0; ret_addr = '0; flag_z = 0; flag_n = 0; flag_v = 0; jindir = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 pc after reset", 32'(pc), 0);
        chk("R1 cond after reset", 32'(cond_flag), 0);
        chk("R1 trap after reset", 32'(trap_req), 0);
        step(mk(0, 0, 3'b000, 2'b00, 3'b000, 3'b000, 24'h0AA));
        chk("R1 cond branch falls through after reset", 32'(pc), 1);
    endtask

    task automatic t_hold;
        goto(24'h000321);
        instr = mk(0, 1, 3'b010, 2'b00, 3'b000, 3'b011, 24'h00BBBB);
        flag_z = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 pc holds without strobe", 32'(pc), 32'h321);
        chk("R2 cond holds without strobe", 32'(cond_flag), 1);
        flag_z = 1'b0;
    endtask

    task automatic t_increment;
        goto(24'h000010);
        for (int i = 0; i < 3; i++) step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b000, 24'h0));
        chk("R3 three increments", 32'(pc), 32'h13);
        goto(24'hFFFFFF);
        step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b000, 24'h0));
        chk("R3 increment wraps", 32'(pc), 0);
    endtask

    task automatic t_jump;
        goto(24'hABCDEF);
        chk("R4 unconditional jump", 32'(pc), 32'hABCDEF);
        step(mk(0, 0, 3'b010, 2'b00, 3'b000, 3'b000, 24'h123456));
        chk("R4 conditional jump taken", 32'(pc), 32'h123456);
        flag_z = 1'b1;
        step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b011, 24'h0));
        flag_z = 1'b0;
        step(mk(0, 0, 3'b010, 2'b00, 3'b000, 3'b000, 24'h654321));
        chk("R4 conditional jump not taken", 32'(pc), 32'h123458);
        step(mk(0, 0, 3'b010, 2'b00, 3'b010, 3'b000, 24'h00ABCD));
        chk("R4 long call", 32'(pc), 32'h00ABCD);
    endtask

    task automatic t_branch;
        goto(24'h123FFF);
        step(mk(0, 1, 3'b000, 2'b00, 3'b000, 3'b000, 24'h000055));
        chk("R5 branch uses page of PC+1", 32'(pc), 32'h124055);
        step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b010, 24'h0));
        step(mk(0, 0, 3'b000, 2'b00, 3'b000, 3'b000, 24'h000111));
        chk("R5 conditional branch falls through", 32'(pc), 32'h124057);
        step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b000, 24'h0));
        step(mk(0, 0, 3'b100, 2'b00, 3'b000, 3'b000, 24'hFFF222));
        chk("R5 conditional branch taken", 32'(pc), 32'h124222);
    endtask

    task automatic t_lowcall;
        goto(24'h777777);
        step(mk(0, 0, 3'b000, 2'b00, 3'b010, 3'b000, 24'hFFFABC));
        chk("R6 low-memory call target", 32'(pc), 32'h000AB0);
    endtask

    task automatic t_dispatch;
        alu_addr = 24'h345678;
        step(mk(0, 0, 3'b000, 2'b01, 3'b000, 3'b000, 24'h000008));
        chk("R7 dispatch plain", 32'(pc), 32'h345678);
        step(mk(0, 1, 3'b000, 2'b01, 3'b001, 3'b000, 24'h0));
        chk("R7 dispatch aligned by bit 61", 32'(pc), 32'h345670);
        step(mk(0, 0, 3'b000, 2'b01, 3'b010, 3'b000, 24'h000008));
        chk("R7 call-dispatch aligned by bit 3", 32'(pc), 32'h345670);
        step(mk(0, 1, 3'b000, 2'b01, 3'b011, 3'b000, 24'h0));
        chk("R7 call-dispatch ignores bit 61", 32'(pc), 32'h345678);
    endtask

    task automatic t_return;
        goto(24'h000200);
        ret_addr = 24'h00BEEF;
        @(negedge clk);
        instr = mk(0, 0, 3'b000, 2'b10, 3'b100, 3'b000, 24'h0);
        #1 chk("R11 legal return not flagged", 32'(illegal), 0);
        step(mk(0, 0, 3'b000, 2'b10, 3'b100, 3'b000, 24'h0));
        chk("R8 return address loaded", 32'(pc), 32'h00BEEF);
    endtask

    task automatic t_conditions;
        for (int code = 0; code < 8; code++) begin
            for (int f = 0; f < 16; f++) begin
                flag_z = f[0]; flag_n = f[1]; flag_v = f[2]; jindir = f[3];
                step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'(code), 24'h0));
                chk($sformatf("R9 condition code %0d flags %0d", code, f),
                    32'(cond_flag), 32'(cond_exp(code, f[0], f[1], f[2], f[3])));
            end
        end
        flag_z = 0; flag_n = 0; flag_v = 0; jindir = 0;
    endtask

    task automatic t_trap;
        goto(24'h000100);
        @(negedge clk);
        flag_z = 1'b1;
        instr = mk(1, 1, 3'b010, 2'b00, 3'b000, 3'b011, 24'h777777);
        advance = 1'b1;
        @(negedge clk);
        chk("R10 trap request raised", 32'(trap_req), 1);
        chk("R10 pc unchanged by trapped instr", 32'(pc), 32'h100);
        chk("R10 cond unchanged by trapped instr", 32'(cond_flag), 1);
        instr = mk(0, 1, 3'b010, 2'b00, 3'b000, 3'b011, 24'h555555);
        @(negedge clk);
        advance = 1'b0;
        chk("R10 trap request one cycle", 32'(trap_req), 0);
        chk("R10 strobe during trap ignored", 32'(pc), 32'h100);
        chk("R10 cond kept during trap", 32'(cond_flag), 1);
        flag_z = 1'b0;
        step(mk(0, 0, 3'b000, 2'b11, 3'b000, 3'b000, 24'h0));
        chk("R10 resumes after trap", 32'(pc), 32'h101);
    endtask

    task automatic t_illegal;
        goto(24'h000300);
        @(negedge clk);
        instr = mk(0, 0, 3'b000, 2'b10, 3'b000, 3'b000, 24'h0);
        #1 chk("R11 return selector without return op", 32'(illegal), 1);
        step(mk(0, 0, 3'b000, 2'b10, 3'b000, 3'b000, 24'h0));
        chk("R11 illegal return acts as increment", 32'(pc), 32'h301);
        @(negedge clk);
        instr = mk(0, 1, 3'b000, 2'b00, 3'b100, 3'b000, 24'h000ABC);
        #1 chk("R11 branch with return op flagged", 32'(illegal), 1);
        step(mk(0, 1, 3'b000, 2'b00, 3'b100, 3'b000, 24'h000ABC));
        chk("R11 illegal branch acts as increment", 32'(pc), 32'h302);
        step(mk(0, 1, 3'b010, 2'b00, 3'b100, 3'b000, 24'h999999));
        chk("R11 illegal jump acts as increment", 32'(pc), 32'h303);
    endtask

    task automatic t_reset_again;
        goto(24'h004444);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-run clears pc", 32'(pc), 0);
        chk("R1 reset mid-run clears cond", 32'(cond_flag), 0);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_increment();
        t_jump();
        t_branch();
        t_lowcall();
        t_dispatch();
        t_return();
        t_conditions();
        t_trap();
        t_illegal();
        t_reset_again();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule